// File: doc/BRIEF.md
# Coprocessor Message Mailbox

This block passes fixed-size 96-bit messages between an application processor (AP) and an I/O coprocessor (IOP). It holds two FIFOs whose direction is fixed: the outbound FIFO carries messages only from the AP to the IOP, and the inbound FIFO carries messages only from the IOP to the AP. Both processors reach the block through one shared register view at the same offsets. A message is built from a 64-bit upper word and a 32-bit lower word, each with its own register.

The sender first writes the upper word into a staging register. Writing the lower word then pushes the whole message as one step. The receiver can peek at the upper word of the head entry without removing it. Reading the lower word pops the message. Each FIFO has a status word that shows full, empty, fill count and a sticky overflow flag.

Four level-sensitive interrupt lines report "receive side has data" and "send side is empty" for each processor. When the acknowledge option is built in, each event is latched and stays asserted until software acknowledges it. If the condition still holds after the acknowledge, the event is latched again one cycle later. Without the option, each line follows its condition directly.

Top module: `cpmbox`

## Requirements
- R1: Writing the lower-word register of a FIFO (outbound 0x808, inbound 0x828) pushes one message when the FIFO is not full. The message is {staged upper word, wdata[31:0]}. The staged upper word is taken from the last write to the upper-word register (0x800 / 0x820). Reading the pop register (0x818 / 0x838) returns {32'b0, lower word} and removes the head. Messages leave each FIFO in the order they were pushed.
- R2: Reading the peek register (0x810 / 0x830) returns the head message's upper word. It does not change the fill count or the head.
- R3: A push to a full FIFO is dropped and sets that FIFO's overflow flag (status bit 0). The flag stays set until a write to the status register with wdata[0]=1.
- R4: Reading the pop or peek register of an empty FIFO returns zero. The read does not move the FIFO's pointers.
- R5: Each FIFO's status register (outbound 0x110, inbound 0x114) reads full in bit 16, empty in bit 17 and the fill count in bits 11:8. The FIFO holds up to DEPTH messages.
- R6: Accesses to one FIFO's registers leave the other FIFO's contents and status unchanged.
- R7: The four interrupt conditions are: AP receive = inbound not empty, AP send = outbound empty, IOP receive = outbound not empty, IOP send = inbound empty.
- R8: With IRQ_CTRL=1, each interrupt is set on the clock edge after its condition is seen. It then stays asserted, even if the condition goes away, until a write of 1 to its acknowledge bit at 0x118. The bits are 0 AP receive, 1 AP send, 2 IOP receive, 3 IOP send. An acknowledged event whose condition still holds is asserted again one cycle later.
- R9: With IRQ_CTRL=0, each interrupt output equals its condition. Writes to 0x118 have no effect.
- R10: Synchronous reset empties both FIFOs and clears the overflow flags, the staged upper words and the latched interrupt events.
- R11: Reading 0x118 returns the four interrupt outputs in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe (pops on the pop register) |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from bus_addr |
| irq_ap_recv | output | 1 | AP: inbound message waiting |
| irq_ap_send | output | 1 | AP: outbound FIFO empty |
| irq_io_recv | output | 1 | IOP: outbound message waiting |
| irq_io_send | output | 1 | IOP: inbound FIFO empty |

## Verification
Read data is combinational, so the bench samples bus_rdata one nanosecond after it drives the address, in the same cycle. Pushes, pops, overflow and flag clears take effect at the next rising edge, so status words are read in the cycle after the access. Raw interrupts follow the fill count at that same edge. Latched interrupts need one more edge, so the bench checks them at the first negedge (low) and at the second negedge (high) after a push or an acknowledge. That is also how it observes the one-cycle drop and re-assertion after an acknowledge.

// File: rtl/cpmbox.sv
module cpmbox #(
  parameter int DEPTH    = 8,
  parameter bit IRQ_CTRL = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wen,
  input  logic        bus_ren,
  input  logic [11:0] bus_addr,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  output logic        irq_ap_recv,
  output logic        irq_ap_send,
  output logic        irq_io_recv,
  output logic        irq_io_send
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [11:0] ACK_ADDR = 12'h118;

  function automatic logic [11:0] ctl_addr(input int d);
    return 12'h110 + 12'(4 * d);
  endfunction

  // slot: 0 upper stage, 1 lower push, 2 peek, 3 pop
  function automatic logic [11:0] data_addr(input int d, input int slot);
    return 12'h800 + 12'(32 * d + 8 * slot);
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic [CW-1:0] cnt  [2];
  logic [95:0]   head [2];
  logic [63:0]   stat [2];
  logic [1:0]    ovf, full, empty;
  logic [3:0]    cond, irq_vec;

  for (genvar d = 0; d < 2; d++) begin : g_fifo
    logic [95:0]   mem_q [DEPTH];
    logic [63:0]   stage_q;
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          push_req, pop_req, push_ok, pop_ok, clr_ovf, stage_wr;

    assign stage_wr = bus_wen && bus_addr == data_addr(d, 0);
    assign push_req = bus_wen && bus_addr == data_addr(d, 1);
    assign pop_req  = bus_ren && bus_addr == data_addr(d, 3);
    assign clr_ovf  = bus_wen && bus_addr == ctl_addr(d) && bus_wdata[0];
    assign push_ok  = push_req && !full[d];
    assign pop_ok   = pop_req && !empty[d];

    always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= {stage_q, bus_wdata[31:0]};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp_q    <= '0;
        rp_q    <= '0;
        cnt_q   <= '0;
        ovf_q   <= 1'b0;
        stage_q <= '0;
      end else begin
        if (stage_wr) stage_q <= bus_wdata;
        if (push_ok) wp_q <= nxt(wp_q);
        if (pop_ok) rp_q <= nxt(rp_q);
        if (push_ok && !pop_ok) cnt_q <= cnt_q + CW'(1);
        else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
        if (push_req && full[d]) ovf_q <= 1'b1;
        else if (clr_ovf) ovf_q <= 1'b0;
      end
    end

    assign cnt[d]   = cnt_q;
    assign ovf[d]   = ovf_q;
    assign head[d]  = mem_q[rp_q];
    assign full[d]  = cnt_q == CW'(DEPTH);
    assign empty[d] = cnt_q == '0;
    assign stat[d]  = (64'(empty[d]) << 17) | (64'(full[d]) << 16) |
                      (64'(cnt_q) << 8) | 64'(ovf_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ACK_ADDR) bus_rdata = 64'(irq_vec);
    for (int i = 0; i < 2; i++) begin
      if (bus_addr == ctl_addr(i)) bus_rdata = stat[i];
      if (!empty[i] && bus_addr == data_addr(i, 2)) bus_rdata = head[i][95:32];
      if (!empty[i] && bus_addr == data_addr(i, 3)) bus_rdata = 64'(head[i][31:0]);
    end
  end

  assign cond = {empty[1], ~empty[0], empty[0], ~empty[1]};

  if (IRQ_CTRL) begin : g_ack
    logic [3:0] pend_q, ack_mask;
    assign ack_mask = (bus_wen && bus_addr == ACK_ADDR) ? bus_wdata[3:0] : 4'b0;
    always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= (pend_q | cond) & ~ack_mask;
    end
    assign irq_vec = pend_q;
  end else begin : g_raw
    assign irq_vec = cond;
  end

  assign irq_ap_recv = irq_vec[0];
  assign irq_ap_send = irq_vec[1];
  assign irq_io_recv = irq_vec[2];
  assign irq_io_send = irq_vec[3];
endmodule

// File: rtl/cpmbox_chk.sv
module cpmbox_chk #(
  parameter int DEPTH    = 8,
  parameter bit IRQ_CTRL = 1'b1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wen,
  input logic          ren,
  input logic [11:0]   addr,
  input logic [63:0]   wdata,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic          ovf_a,
  input logic [3:0]    irq_vec
);
  logic push_a, ack2;
  assign push_a = wen && addr == 12'h808;
  assign ack2   = wen && addr == 12'h118 && wdata[2];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_a <= CW'(DEPTH) && cnt_b <= CW'(DEPTH)); // R5
  AST_PUSH_ONE: assert property (@(posedge clk) disable iff (rst)
    (push_a && cnt_a < CW'(DEPTH)) |=> cnt_a == $past(cnt_a) + CW'(1)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push_a && cnt_a == CW'(DEPTH)) |=> (cnt_a == CW'(DEPTH) && ovf_a)); // R3
  AST_PEEK_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ren && addr == 12'h810) |=> $stable(cnt_a)); // R2
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ren && addr == 12'h818 && cnt_a == '0) |=> cnt_a == '0); // R4
  AST_DIR_ISOLATE: assert property (@(posedge clk) disable iff (rst)
    push_a |=> $stable(cnt_b)); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (IRQ_CTRL && irq_vec[2] && !ack2) |=> irq_vec[2]); // R8
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (IRQ_CTRL && ack2) |=> !irq_vec[2]); // R8
  AST_IRQ_RAW: assert property (@(posedge clk) disable iff (rst)
    !IRQ_CTRL |-> (irq_vec[2] == (cnt_a != '0) && irq_vec[0] == (cnt_b != '0))); // R9
endmodule

bind cpmbox cpmbox_chk #(.DEPTH(DEPTH), .IRQ_CTRL(IRQ_CTRL)) u_chk (
  .clk(clk), .rst(rst), .wen(bus_wen), .ren(bus_ren), .addr(bus_addr),
  .wdata(bus_wdata), .cnt_a(cnt[0]), .cnt_b(cnt[1]), .ovf_a(ovf[0]),
  .irq_vec(irq_vec)
);

// File: tb/cpmbox_tb.sv
`timescale 1ns/1ps
module cpmbox_tb;
  localparam int DEPTH = 8;
  localparam logic [11:0] ACK = 12'h118;

  logic clk = 1'b0, rst = 1'b1, wen = 1'b0, ren = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  wire  [63:0] rdata, rdata_raw;
  wire  [3:0]  irq, irq_raw;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cpmbox #(.DEPTH(DEPTH), .IRQ_CTRL(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_wen(wen), .bus_ren(ren), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_ap_recv(irq[0]),
    .irq_ap_send(irq[1]), .irq_io_recv(irq[2]), .irq_io_send(irq[3]));

  cpmbox #(.DEPTH(DEPTH), .IRQ_CTRL(1'b0)) u_raw (
    .clk(clk), .rst(rst), .bus_wen(wen), .bus_ren(ren), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_raw), .irq_ap_recv(irq_raw[0]),
    .irq_ap_send(irq_raw[1]), .irq_io_recv(irq_raw[2]), .irq_io_send(irq_raw[3]));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); wen = 1'b1; addr = a; wdata = d;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk); ren = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); ren = 1'b0;
  endtask

  function automatic logic [63:0] hi(input int d, input int k);
    return (64'h1111_2222_0000_0000 * 64'(d + 1)) ^ (64'(k) * 64'h0001_0001_0101);
  endfunction
  function automatic logic [31:0] lo(input int d, input int k);
    return 32'hF00D_0000 | 32'(d << 8) | 32'(k);
  endfunction
  function automatic logic [63:0] st(input int n, input bit o);
    return ((n == 0) ? 64'h2_0000 : 64'h0) | ((n == DEPTH) ? 64'h1_0000 : 64'h0) |
           (64'(n) << 8) | 64'(o);
  endfunction
  function automatic logic [11:0] ctl(input int d);
    return 12'h110 + 12'(4 * d);
  endfunction
  function automatic logic [11:0] dat(input int d, input int slot);
    return 12'h800 + 12'(32 * d + 8 * slot);
  endfunction

  task automatic push(input int d, input int k);
    wr(dat(d, 0), hi(d, k));
    wr(dat(d, 1), 64'hDEAD_BEEF_0000_0000 | 64'(lo(d, k)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state, R7 conditions
    rd(ctl(0), v); chk("R10 outbound status", v, st(0, 0));
    rd(ctl(1), v); chk("R10 inbound status", v, st(0, 0));
    chk("R7 latched irqs after reset", 64'(irq), 64'hA);
    chk("R9 raw irqs after reset", 64'(irq_raw), 64'hA);

    // interrupt timing
    push(0, 0);
    chk("R9 raw io_recv follows push", 64'(irq_raw[2]), 64'h1);
    chk("R8 latched io_recv one edge later", 64'(irq[2]), 64'h0);
    chk("R9 raw ap_send drops", 64'(irq_raw[1]), 64'h0);
    @(negedge clk);
    chk("R8 latched io_recv set", 64'(irq[2]), 64'h1);
    chk("R8 ap_send stays until ack", 64'(irq[1]), 64'h1);
    wr(ACK, 64'h2);
    chk("R8 ap_send cleared by ack", 64'(irq[1]), 64'h0);
    @(negedge clk);
    chk("R8 ap_send stays low", 64'(irq[1]), 64'h0);
    wr(ACK, 64'h4);
    chk("R8 io_recv drops after ack", 64'(irq[2]), 64'h0);
    @(negedge clk);
    chk("R8 io_recv re-asserts", 64'(irq[2]), 64'h1);
    rd(ACK, v); chk("R11 ack read", v, 64'hC);
    rd(dat(0, 3), v); chk("R1 pop lower word", v, 64'(lo(0, 0)));
    chk("R9 raw io_recv drops after pop", 64'(irq_raw[2]), 64'h0);
    chk("R8 io_recv held after drain", 64'(irq[2]), 64'h1);
    wr(ACK, 64'hF);
    chk("R9 ack has no effect on raw", 64'(irq_raw), 64'hA);
    @(negedge clk);
    chk("R8 only live conditions return", 64'(irq), 64'hA);

    // sweeps per direction
    for (int d = 0; d < 2; d++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        push(d, n - 1);
        rd(ctl(d), v); chk("R5 status while filling", v, st(n, 0));
      end
      rd(ctl(1 - d), v); chk("R6 other FIFO untouched", v, st(0, 0));
      chk("R7 raw irq pattern when full", 64'(irq_raw),
          (d == 0) ? 64'hC : 64'h3);
      push(d, 99);
      rd(ctl(d), v); chk("R3 overflow flagged", v, st(DEPTH, 1));
      for (int k = 0; k < DEPTH; k++) begin
        rd(dat(d, 2), v); chk("R2 peek upper word", v, hi(d, k));
        rd(dat(d, 2), v); chk("R2 peek repeat", v, hi(d, k));
        rd(ctl(d), v); chk("R2 peek keeps count", v, st(DEPTH - k, 1));
        rd(dat(d, 3), v); chk("R1 pop order", v, 64'(lo(d, k)));
      end
      rd(dat(d, 3), v); chk("R4 pop empty zero", v, 64'h0);
      rd(dat(d, 2), v); chk("R4 peek empty zero", v, 64'h0);
      rd(ctl(d), v); chk("R3 overflow sticky", v, st(0, 1));
      wr(ctl(d), 64'h1);
      rd(ctl(d), v); chk("R3 overflow cleared", v, st(0, 0));
      push(d, 5);
      rd(dat(d, 2), v); chk("R4 pointers intact upper", v, hi(d, 5));
      rd(dat(d, 3), v); chk("R4 pointers intact lower", v, 64'(lo(d, 5)));
    end

    // R10 reset mid-traffic
    push(1, 3);
    wr(dat(0, 0), 64'h1234);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R10 latched irqs cleared", 64'(irq), 64'h0);
    rd(ctl(1), v); chk("R10 inbound emptied", v, st(0, 0));
    wr(dat(0, 1), 64'h77);
    rd(dat(0, 2), v); chk("R10 staging cleared", v, 64'h0);
    rd(dat(0, 3), v); chk("R10 lower word after reset", v, 64'h77);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule